// File: doc/BRIEF.md
# Retriggerable one-shot pulse generator

This block turns a qualified input edge into an output pulse of a programmed length, counted in clock cycles. Each channel has two edge-trigger inputs, each gated by the level of the other: a falling edge on one fires while the other is high, and a rising edge on the other fires while the first is low. A trigger that arrives while a pulse is running restarts the count, so the pulse ends one full programmed width after the last accepted trigger. Back-to-back triggers can therefore hold the output high without a break. A programmable minimum spacing makes the channel ignore a retrigger that comes too soon after the trigger it last accepted.

Each channel also has an active-low clear input. While it is low, the true output is low and the complementary output is high at once, and no trigger is taken. Releasing the clear never fires a pulse. After the block's own reset, a channel takes no trigger until its clear input has been low at least once, so no stray pulse can appear at start-up. The trigger inputs and the clear input may be asynchronous to the clock: they pass through two-flop synchronisers. Several channels sit side by side and share nothing but the clock and reset.

Top module: `retrig_oneshot`

## Requirements
- R1: A falling edge on `fall_trig_i[c]` while `rise_trig_i[c]` is 1 fires a trigger. The true output `pulse_o[c]` goes high on the third rising clock edge after the input changes.
- R2: A rising edge on `rise_trig_i[c]` while `fall_trig_i[c]` is 0 fires a trigger, with the same three-edge latency as R1.
- R3: An accepted trigger samples the 16-bit slice `width_i[16*c+15:16*c]` and holds `pulse_o[c]` high for exactly that many cycles. A value of 0 is treated as 1.
- R4: A trigger accepted during a running pulse reloads the count, so the pulse ends one full width after the last accepted trigger. Triggers spaced closer than the width keep the output high with no gap.
- R5: While a pulse runs, a trigger is accepted only if at least `min_gap_i[8*c+7:8*c]` cycles have passed since the previous accepted trigger. A trigger inside that window is ignored and the pulse ends as if it never came. A spacing equal to the limit is accepted, and a limit of 0 accepts every trigger.
- R6: While `clr_ni[c]` is 0, `pulse_o[c]` is 0 in the same cycle, a running pulse is ended, and triggers are ignored. The clear must span at least one rising clock edge. After the clear is released, the channel triggers normally again.
- R7: The rising edge of `clr_ni[c]` never starts a pulse, even when the trigger levels qualify.
- R8: Edges that do not qualify start nothing: a falling edge on `fall_trig_i` while `rise_trig_i` is 0, a rising edge on `rise_trig_i` while `fall_trig_i` is 1, and rising edges on `fall_trig_i` or falling edges on `rise_trig_i`. A running pulse keeps its full length when the inputs leave the qualifying levels.
- R9: After `rst_ni` is released, a channel ignores all triggers until its `clr_ni[c]` has been seen low.
- R10: `pulse_no[c]` is the complement of `pulse_o[c]` in every cycle, including while `rst_ni` or `clr_ni[c]` is low.
- R11: Channels are independent. A trigger on one channel does not change the output of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| clr_ni | input | NUM_CH | Per-channel active-low clear; ends the pulse and blocks triggers |
| fall_trig_i | input | NUM_CH | Falling-edge trigger, gated by `rise_trig_i` being high |
| rise_trig_i | input | NUM_CH | Rising-edge trigger, gated by `fall_trig_i` being low |
| width_i | input | NUM_CH*16 | Pulse width in cycles, one 16-bit slice per channel |
| min_gap_i | input | NUM_CH*8 | Minimum spacing between retriggers in cycles, one 8-bit slice per channel |
| pulse_o | output | NUM_CH | True pulse output |
| pulse_no | output | NUM_CH | Complementary pulse output |

## Verification
The assertions check four properties on every cycle. The complementary output is always the inverse of the true output. A low clear always forces the true output low. No pulse appears in the cycle after a clear is released. Every rising edge of the output can be traced back, through the three-edge latency, to a qualifying edge and gate level on the inputs. Only the bench's scenarios can show the pulse length, how a retrigger extends the pulse, the minimum-spacing window at and just inside its limit, the start-up arming, and that the channels do not disturb each other, because each depends on a programmed count or on an earlier trigger.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;
  parameter int unsigned OS_WIDTH_W = 16;
  parameter int unsigned OS_GAP_W   = 8;
  parameter int unsigned OS_SYNC_N  = 2;

  // synchroniser lane order per channel
  typedef struct packed {
    logic clr_n;
    logic rise;
    logic fall;
  } os_lane_t;

  localparam os_lane_t OS_LANE_IDLE = '{clr_n: 1'b1, rise: 1'b0, fall: 1'b1};
endpackage

// File: rtl/os_sync.sv
module os_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stg_q[s] <= RST_VAL;
          else         stg_q[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stg_q[s] <= RST_VAL;
          else         stg_q[s] <= stg_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/os_chan.sv
module os_chan #(
  parameter int unsigned WIDTH_W = 16,
  parameter int unsigned GAP_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fall_s_i,
  input  logic               rise_s_i,
  input  logic               clr_s_ni,
  input  logic               clr_raw_ni,
  input  logic [WIDTH_W-1:0] width_i,
  input  logic [GAP_W-1:0]   min_gap_i,
  output logic               pulse_o,
  output logic               pulse_no
);
  localparam logic [GAP_W-1:0]   GAP_MAX = {GAP_W{1'b1}};
  localparam logic [WIDTH_W-1:0] W_ONE   = WIDTH_W'(1);

  logic               fall_d_q, rise_d_q;
  logic               armed_q;
  logic [WIDTH_W-1:0] cnt_q;
  logic [GAP_W-1:0]   gap_q;
  logic               clr_act, busy, fire, accept;
  logic [WIDTH_W-1:0] load_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fall_d_q <= 1'b1;
      rise_d_q <= 1'b0;
    end else begin
      fall_d_q <= fall_s_i;
      rise_d_q <= rise_s_i;
    end
  end

  // raw clear stops the count at the first edge it spans
  assign clr_act = !clr_s_ni || !clr_raw_ni;
  assign busy    = (cnt_q != '0);
  assign fire    = (fall_d_q & ~fall_s_i & rise_s_i) |
                   (~rise_d_q & rise_s_i & ~fall_s_i);
  assign accept  = fire && armed_q && !clr_act && (!busy || gap_q >= min_gap_i);
  assign load_w  = (width_i == '0) ? W_ONE : width_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        armed_q <= 1'b0;
    else if (!clr_s_ni) armed_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_act) cnt_q <= '0;
    else if (accept)  cnt_q <= load_w;
    else if (busy)    cnt_q <= cnt_q - W_ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               gap_q <= GAP_MAX;
    else if (clr_act)          gap_q <= GAP_MAX;
    else if (accept)           gap_q <= GAP_W'(1);
    else if (gap_q != GAP_MAX) gap_q <= gap_q + GAP_W'(1);
  end

  assign pulse_o  = busy & clr_raw_ni;
  assign pulse_no = ~pulse_o;
endmodule

// File: rtl/retrig_oneshot.sv
module retrig_oneshot
  import oneshot_pkg::*;
#(
  parameter int unsigned NUM_CH = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_CH-1:0]            clr_ni,
  input  logic [NUM_CH-1:0]            fall_trig_i,
  input  logic [NUM_CH-1:0]            rise_trig_i,
  input  logic [NUM_CH*OS_WIDTH_W-1:0] width_i,
  input  logic [NUM_CH*OS_GAP_W-1:0]   min_gap_i,
  output logic [NUM_CH-1:0]            pulse_o,
  output logic [NUM_CH-1:0]            pulse_no
);
  localparam int unsigned LANE_W = $bits(os_lane_t);

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      os_lane_t lane_raw, lane_s;

      assign lane_raw = '{clr_n: clr_ni[c], rise: rise_trig_i[c], fall: fall_trig_i[c]};

      os_sync #(
        .W      (LANE_W),
        .STAGES (OS_SYNC_N),
        .RST_VAL(OS_LANE_IDLE)
      ) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (lane_raw),
        .q_o   (lane_s)
      );

      os_chan #(
        .WIDTH_W(OS_WIDTH_W),
        .GAP_W  (OS_GAP_W)
      ) u_chan (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .fall_s_i  (lane_s.fall),
        .rise_s_i  (lane_s.rise),
        .clr_s_ni  (lane_s.clr_n),
        .clr_raw_ni(clr_ni[c]),
        .width_i   (width_i[c*OS_WIDTH_W +: OS_WIDTH_W]),
        .min_gap_i (min_gap_i[c*OS_GAP_W +: OS_GAP_W]),
        .pulse_o   (pulse_o[c]),
        .pulse_no  (pulse_no[c])
      );
    end
  endgenerate
endmodule

// File: rtl/retrig_oneshot_chk.sv
module retrig_oneshot_chk #(
  parameter int unsigned NUM_CH = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CH-1:0] clr_ni,
  input logic [NUM_CH-1:0] fall_trig_i,
  input logic [NUM_CH-1:0] rise_trig_i,
  input logic [NUM_CH-1:0] pulse_o,
  input logic [NUM_CH-1:0] pulse_no
);
  logic [2:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cyc_q <= '0;
    else if (cyc_q != 3'd7) cyc_q <= cyc_q + 3'd1;
  end

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
      p_compl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pulse_no[c] == ~pulse_o[c]);

      p_clr_force_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_ni[c] |-> !pulse_o[c]);

      p_release_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cyc_q != 3'd0 && $rose(clr_ni[c])) |=> !pulse_o[c]);

      // R1 and R2: a new pulse needs a gated edge three edges earlier
      p_qual_edge_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cyc_q >= 3'd5 && $rose(pulse_o[c])) |->
          (($past(fall_trig_i[c], 4) && !$past(fall_trig_i[c], 3) && $past(rise_trig_i[c], 3)) ||
           (!$past(rise_trig_i[c], 4) && $past(rise_trig_i[c], 3) && !$past(fall_trig_i[c], 3))));
    end
  endgenerate
endmodule

bind retrig_oneshot retrig_oneshot_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .clr_ni     (clr_ni),
  .fall_trig_i(fall_trig_i),
  .rise_trig_i(rise_trig_i),
  .pulse_o    (pulse_o),
  .pulse_no   (pulse_no)
);

// File: tb/tb_retrig_oneshot.sv
`timescale 1ns/1ps
module tb_retrig_oneshot;
  localparam int NCH = 2;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [1:0]  clr, fa, rb;
  logic [31:0] width_v;
  logic [15:0] gap_v;
  logic [1:0]  pulse_o, pulse_no;

  int checks = 0;
  int fails  = 0;

  always #2 clk_i = ~clk_i;

  retrig_oneshot #(.NUM_CH(NCH)) dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_ni     (clr),
    .fall_trig_i(fa),
    .rise_trig_i(rb),
    .width_i    (width_v),
    .min_gap_i  (gap_v),
    .pulse_o    (pulse_o),
    .pulse_no   (pulse_no)
  );

  // {a_before, b_before, a_after, b_after, width[7:0], expected length[7:0]}
  localparam logic [19:0] VECS [8] = '{
    {4'b1101, 8'd5, 8'd5},  // R1 falling A, B high
    {4'b1000, 8'd5, 8'd0},  // R8 falling A, B low
    {4'b0001, 8'd7, 8'd7},  // R2 rising B, A low
    {4'b1011, 8'd7, 8'd0},  // R8 rising B, A high
    {4'b0010, 8'd4, 8'd0},  // R8 rising A
    {4'b1110, 8'd4, 8'd0},  // R8 falling B
    {4'b1101, 8'd1, 8'd1},  // R3 width 1
    {4'b0001, 8'd0, 8'd1}   // R3 width 0 acts as 1
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // reach levels on channel 0 without passing a qualifying edge
  task automatic set_levels(input logic a0, input logic b0);
    @(negedge clk_i); fa[0] = 1'b1; rb[0] = 1'b0;
    repeat (4) @(negedge clk_i);
    rb[0] = b0;
    repeat (4) @(negedge clk_i);
    fa[0] = a0;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic measure(input int ch, input int win, output int first, output int len);
    first = 0; len = 0;
    for (int k = 1; k <= win; k++) begin
      @(negedge clk_i);
      if (pulse_o[ch]) begin
        if (first == 0) first = k;
        len++;
      end
    end
  endtask

  // A falls at k=0; scheduled follow-up edges; count high samples and last one
  task automatic run_sched(input int w, input int gap, input int t_a_up, input int t_a_dn,
                           input int t_b_dn, input int exp_len, input int exp_last,
                           input string tag);
    int len, last;
    len = 0; last = 0;
    width_v[15:0] = 16'(w);
    gap_v[7:0]    = 8'(gap);
    set_levels(1'b1, 1'b1);
    fa[0] = 1'b0;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk_i);
      if (pulse_o[0]) begin len++; last = k; end
      if (k == t_a_up) fa[0] = 1'b1;
      if (k == t_a_dn) fa[0] = 1'b0;
      if (k == t_b_dn) rb[0] = 1'b0;
    end
    chk({tag, " length"}, len, exp_len);
    chk({tag, " last high sample"}, last, exp_last);
  endtask

  initial begin
    #(4 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int first, len, last;
    rst_ni = 1'b0; clr = 2'b11; fa = 2'b11; rb = 2'b00;
    width_v = {16'd4, 16'd5}; gap_v = '0;
    repeat (3) @(negedge clk_i);
    chk("R10 reset pulse_o", int'(pulse_o), 0);
    chk("R10 reset pulse_no", int'(pulse_no), 3);
    rst_ni = 1'b1;

    // R9: not armed before a clear
    set_levels(1'b1, 1'b1);
    fa[0] = 1'b0;
    measure(0, 10, first, len);
    chk("R9 trigger before first clear", len, 0);

    @(negedge clk_i); clr = 2'b00;
    repeat (3) @(negedge clk_i);
    clr = 2'b11;
    repeat (4) @(negedge clk_i);

    for (int i = 0; i < 8; i++) begin
      logic [19:0] v;
      v = VECS[i];
      width_v[15:0] = {8'd0, v[15:8]};
      set_levels(v[19], v[18]);
      fa[0] = v[17]; rb[0] = v[16];
      measure(0, 12, first, len);
      chk($sformatf("table entry %0d (R1 R2 R3 R8) length", i), len, int'(v[7:0]));
      if (v[7:0] != 0) chk($sformatf("table entry %0d (R1 R2) latency", i), first, 3);
    end

    run_sched(10, 0, 2, 4, 0, 14, 16, "R4 retrigger");
    run_sched(10, 6, 2, 4, 0, 10, 12, "R5 inside window");
    run_sched(10, 6, 3, 6, 0, 16, 18, "R5 at limit");
    run_sched(8, 0, 2, 0, 2, 8, 10, "R8 levels leave");

    // R4: retrigger every 2 cycles, width 6: continuous high
    width_v[15:0] = 16'd6; gap_v[7:0] = 8'd0;
    set_levels(1'b1, 1'b1);
    fa[0] = 1'b0;
    len = 0; last = 0;
    for (int k = 1; k <= 44; k++) begin
      @(negedge clk_i);
      if (pulse_o[0]) begin len++; last = k; end
      if (k <= 30) fa[0] = k[0];
    end
    chk("R4 held high length", len, 36);
    chk("R4 held high last sample", last, 38);

    // R6 and R7: clear during pulse, trigger during clear, release with qualifying levels
    width_v[15:0] = 16'd20;
    set_levels(1'b1, 1'b1);
    fa[0] = 1'b0;
    repeat (5) @(negedge clk_i);
    chk("R6 pulse running before clear", int'(pulse_o[0]), 1);
    clr[0] = 1'b0;
    #1;
    chk("R6 clear forces pulse_o low", int'(pulse_o[0]), 0);
    chk("R10 clear pulse_no high", int'(pulse_no[0]), 1);
    @(negedge clk_i); fa[0] = 1'b1;
    @(negedge clk_i); fa[0] = 1'b0;
    repeat (3) @(negedge clk_i);
    clr[0] = 1'b1;
    measure(0, 25, first, len);
    chk("R7 release and trigger during clear", len, 0);
    width_v[15:0] = 16'd3;
    fa[0] = 1'b1;
    repeat (4) @(negedge clk_i);
    fa[0] = 1'b0;
    measure(0, 10, first, len);
    chk("R6 trigger after release", len, 3);

    // R11: channel 1 alone
    @(negedge clk_i); rb[1] = 1'b1;
    repeat (4) @(negedge clk_i);
    fa[1] = 1'b0;
    len = 0; last = 0;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk_i);
      if (pulse_o[1]) len++;
      if (pulse_o[0]) last++;
    end
    chk("R11 channel 1 length", len, 4);
    chk("R11 channel 0 untouched", last, 0);

    finish_run();
  end
endmodule